// File: doc/BRIEF.md
# Synthesizer Configuration and Lock Sequencer

This block is the digital controller in front of an analog frequency synthesizer. Software uses a plain register-write port to place the integer multiplier, the fractional multiplier, the two reference dividers and the reference source in shadow registers. The values drive the synthesizer only after a one-cycle commit strobe. A separate enable bit takes effect on the write itself. The block runs on the reference clock, and every lock interval is counted in cycles of that clock.

After the enable rises, or after a commit that actually changes something while the synthesizer runs, the `ready` output stays low for a lock interval. The length of that interval depends on the kind of change. The block also produces a frequency code for the VCO from the active settings, for status readback. In low-voltage mode the pre-divider Q is forced to a fixed value.

Write map: address 0 holds the integer multiplier in data[9:0]. Address 1 holds the fractional multiplier in data[9:0]. Address 2 holds N in data[4:0] and Q in data[9:5]. Address 3 holds the source in data[0] (0 = crystal, 1 = internal oscillator) and the enable in data[1].

Top module: `synth_lock_ctrl`

## Requirements
- R1: While reset is applied and on the first cycle after it, `syn_en` and `ready` are 0, and all active settings and `vco_code` are 0.
- R2: A write to addresses 0, 1, 2, or to the source bit at address 3, changes no active output until a commit.
- R3: A commit copies every shadow setting to the active outputs on the clock edge that samples it. A write in the same cycle as a commit lands only in shadow.
- R4: When the enable changes from 0 to 1, `ready` is low for exactly 512 cycles after the capturing edge and rises on the 512th edge.
- R5: A commit while enabled that changes the integer multiplier, the fractional multiplier, Q or N drops `ready` for exactly 128 cycles.
- R6: A commit while enabled that changes the reference source drops `ready` for exactly 128 cycles.
- R7: A commit during a lock wait restarts the wait with the interval of the new change. If the enable rises in the same cycle as a commit, the 512-cycle interval applies.
- R8: A commit that changes no setting leaves `ready` high.
- R9: Writing enable = 0 drops `ready` and `syn_en` on the next edge and clears the lock count, so a later enable waits the full 512 cycles.
- R10: While `low_volt` is 1, the Q output and the Q used in the frequency code are 3, whatever value is programmed.
- R11: One cycle after the active settings, `low_volt` or `xtal_code` change, `vco_code` equals floor(ref × (MINT×1024 + MFRAC) / ((Q+1)(N+1)×1024)). ref is `xtal_code` for source 0 and 16 for source 1.
- R12: A commit while disabled updates the active settings and keeps `ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 10 | Register write data |
| commit | input | 1 | Applies shadow settings to the synthesizer |
| low_volt | input | 1 | Low-voltage mode, forces Q to 3 |
| xtal_code | input | 8 | Frequency code of the crystal reference |
| syn_en | output | 1 | Synthesizer enable |
| ready | output | 1 | Lock complete |
| act_mint | output | 10 | Active integer multiplier |
| act_mfrac | output | 10 | Active fractional multiplier |
| act_q | output | 5 | Effective Q divider |
| act_n | output | 5 | Active N divider |
| act_src | output | 1 | Active reference source |
| vco_code | output | 18 | Computed VCO frequency code |

## Verification
The bench runs a fixed-seed random sequence while the synthesizer is enabled. Each step writes new multiplier, divider and source values, or repeats the current ones. This separates commits that must start the 128-cycle wait from commits that must leave `ready` high. The same steps vary `low_volt` and `xtal_code`, which tests the frequency code against a full-precision reference division. Directed cases cover the 512-cycle power-up wait and a commit while disabled. They also cover a commit that restarts a running wait, and an enable that rises together with a commit. The last directed cases clear the enable both in the middle of a wait and after lock.

// File: rtl/synth_pkg.sv
// Package: shared types for the synthesizer lock sequencer.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package synth_pkg;

    // Reasons a lock wait can start; several may be set in one cycle.
    typedef struct packed {
        logic pwr_up;     // enable went from 0 to 1
        logic mult_div;   // multiplier or divider field changed by commit
        logic ref_sw;     // reference source changed by commit
    } lock_cause_t;

    // Register addresses of the write port.
    typedef enum logic [1:0] {
        ADR_MINT  = 2'd0,
        ADR_MFRAC = 2'd1,
        ADR_DIV   = 2'd2,
        ADR_CTRL  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/synth_cfg_regs.sv
// Module: shadow and active register pairs plus the enable bit.
// Writes land in shadow; commit copies shadow to active on the same edge.
// The enable bit acts on write. Assumes wr_data is at least MINT_W, MFRAC_W
// and 2*DIV_W bits wide.
module synth_cfg_regs
    import synth_pkg::*;
#(
    parameter int MINT_W  = 10,
    parameter int MFRAC_W = 10,
    parameter int DIV_W   = 5,
    parameter int DATA_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               commit,
    output logic [MINT_W-1:0]  act_mint,
    output logic [MFRAC_W-1:0] act_mfrac,
    output logic [DIV_W-1:0]   act_q,
    output logic [DIV_W-1:0]   act_n,
    output logic               act_src,
    output logic               en_q,
    output lock_cause_t        cause,
    output logic               en_next
);

    logic [MINT_W-1:0]  sh_mint;
    logic [MFRAC_W-1:0] sh_mfrac;
    logic [DIV_W-1:0]   sh_q;
    logic [DIV_W-1:0]   sh_n;
    logic               sh_src;
    logic               ctrl_wr;
    logic               mult_diff;
    logic               src_diff;

    // Decode a write to the control address.
    assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

    // Next value of the enable bit, used by the lock timer in the same cycle.
    always_comb begin
        en_next = en_q;
        if (ctrl_wr) en_next = wr_data[1];
    end

    // Compare shadow and active to classify what a commit would change.
    always_comb begin
        mult_diff = (sh_mint != act_mint) || (sh_mfrac != act_mfrac) ||
                    (sh_q != act_q) || (sh_n != act_n);
        src_diff  = (sh_src != act_src);
    end

    // Build the lock cause vector for the timer.
    always_comb begin
        cause.pwr_up   = en_next && !en_q;
        cause.mult_div = commit && en_q && mult_diff;
        cause.ref_sw   = commit && en_q && src_diff;
    end

    // Shadow registers: capture software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mint  <= '0;
            sh_mfrac <= '0;
            sh_q     <= '0;
            sh_n     <= '0;
            sh_src   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MINT:  sh_mint  <= wr_data[MINT_W-1:0];
                ADR_MFRAC: sh_mfrac <= wr_data[MFRAC_W-1:0];
                ADR_DIV: begin
                    sh_n <= wr_data[DIV_W-1:0];
                    sh_q <= wr_data[2*DIV_W-1:DIV_W];
                end
                default:   sh_src   <= wr_data[0];
            endcase
        end
    end

    // Active registers: load from shadow only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mint  <= '0;
            act_mfrac <= '0;
            act_q     <= '0;
            act_n     <= '0;
            act_src   <= 1'b0;
        end else if (commit) begin
            act_mint  <= sh_mint;
            act_mfrac <= sh_mfrac;
            act_q     <= sh_q;
            act_n     <= sh_n;
            act_src   <= sh_src;
        end
    end

    // Enable register: acts on write, no commit needed.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_next;
    end

endmodule

// File: rtl/synth_lock_timer.sv
// Module: lock-wait counter. Loads the longest interval among the active
// causes and counts down once per reference clock. ready is high when the
// synthesizer is enabled and the count is zero. Clearing the enable zeroes
// the count. Assumes intervals fit in CNT_W bits.
module synth_lock_timer
    import synth_pkg::*;
#(
    parameter int LOCK_PWR = 512,
    parameter int LOCK_CHG = 128,
    parameter int LOCK_SRC = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_q,
    input  logic        en_next,
    input  lock_cause_t cause,
    output logic        ready
);

    localparam int MAX_A  = (LOCK_CHG > LOCK_SRC) ? LOCK_CHG : LOCK_SRC;
    localparam int MAX_I  = (LOCK_PWR > MAX_A) ? LOCK_PWR : MAX_A;
    localparam int CNT_W  = $clog2(MAX_I + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             load;

    // Pick the longest interval of all causes present in this cycle.
    always_comb begin
        load_val = '0;
        if (cause.mult_div && (CNT_W'(LOCK_CHG) > load_val)) load_val = CNT_W'(LOCK_CHG);
        if (cause.ref_sw   && (CNT_W'(LOCK_SRC) > load_val)) load_val = CNT_W'(LOCK_SRC);
        if (cause.pwr_up   && (CNT_W'(LOCK_PWR) > load_val)) load_val = CNT_W'(LOCK_PWR);
        load = cause.pwr_up || cause.mult_div || cause.ref_sw;
    end

    // Countdown: clear when disabled, restart on a new cause, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!en_next)      cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    // Ready once enabled and the wait has run out.
    assign ready = en_q && (cnt == '0);

endmodule

// File: rtl/synth_vco_calc.sv
// Module: VCO frequency code from the active settings, truncating integer
// division. The fraction is MFRAC_W bits, so {mint,mfrac} equals
// mint*2^MFRAC_W + mfrac. VCO_PIPE selects a registered (1) or
// combinational (0) output.
module synth_vco_calc #(
    parameter int MINT_W   = 10,
    parameter int MFRAC_W  = 10,
    parameter int DIV_W    = 5,
    parameter int REF_W    = 8,
    parameter int INT_CODE = 16,
    parameter bit VCO_PIPE = 1'b1,
    localparam int VCO_W   = REF_W + MINT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REF_W-1:0]   xtal_code,
    input  logic               src,
    input  logic [MINT_W-1:0]  mint,
    input  logic [MFRAC_W-1:0] mfrac,
    input  logic [DIV_W-1:0]   q,
    input  logic [DIV_W-1:0]   n,
    output logic [VCO_W-1:0]   vco_code
);

    localparam int NUM_W = REF_W + MINT_W + MFRAC_W;
    localparam int DEN_W = 2 * (DIV_W + 1);

    logic [REF_W-1:0]  ref_sel;
    logic [DIV_W:0]    q_p1;
    logic [DIV_W:0]    n_p1;
    logic [DEN_W-1:0]  den;
    logic [NUM_W-1:0]  num;
    logic [NUM_W-1:0]  quo;
    logic [VCO_W-1:0]  code_next;

    // Select the reference code and form numerator and divider product.
    always_comb begin
        ref_sel = src ? REF_W'(INT_CODE) : xtal_code;
        q_p1    = {1'b0, q} + 1'b1;
        n_p1    = {1'b0, n} + 1'b1;
        den     = DEN_W'(q_p1) * DEN_W'(n_p1);
        num     = NUM_W'(ref_sel) * NUM_W'({mint, mfrac});
        quo     = num / NUM_W'(den);
        code_next = quo[NUM_W-1:MFRAC_W];
    end

    generate
        if (VCO_PIPE) begin : g_reg
            // Register the code to cut the divider path.
            always_ff @(posedge clk) begin
                if (!rst_n) vco_code <= '0;
                else        vco_code <= code_next;
            end
        end else begin : g_comb
            assign vco_code = code_next;
        end
    endgenerate

endmodule

// File: rtl/synth_lock_ctrl.sv
// Top: synthesizer configuration and lock sequencer. Runs on the reference
// clock and ties together the register pairs, the lock timer and the VCO
// code calculator. In low-voltage mode Q is replaced by LV_Q.
module synth_lock_ctrl
    import synth_pkg::*;
#(
    parameter int MINT_W   = 10,
    parameter int MFRAC_W  = 10,
    parameter int DIV_W    = 5,
    parameter int REF_W    = 8,
    parameter int DATA_W   = 10,
    parameter int INT_CODE = 16,
    parameter int LV_Q     = 3,
    parameter int LOCK_PWR = 512,
    parameter int LOCK_CHG = 128,
    parameter int LOCK_SRC = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      commit,
    input  logic                      low_volt,
    input  logic [REF_W-1:0]          xtal_code,
    output logic                      syn_en,
    output logic                      ready,
    output logic [MINT_W-1:0]         act_mint,
    output logic [MFRAC_W-1:0]        act_mfrac,
    output logic [DIV_W-1:0]          act_q,
    output logic [DIV_W-1:0]          act_n,
    output logic                      act_src,
    output logic [REF_W+MINT_W-1:0]   vco_code
);

    logic [DIV_W-1:0] raw_q;
    logic [DIV_W-1:0] eff_q;
    logic             en_next;
    lock_cause_t      cause;

    // Register pairs and enable.
    synth_cfg_regs #(
        .MINT_W (MINT_W),
        .MFRAC_W(MFRAC_W),
        .DIV_W  (DIV_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (commit),
        .act_mint (act_mint),
        .act_mfrac(act_mfrac),
        .act_q    (raw_q),
        .act_n    (act_n),
        .act_src  (act_src),
        .en_q     (syn_en),
        .cause    (cause),
        .en_next  (en_next)
    );

    // Low-voltage override of the pre-divider.
    always_comb begin
        eff_q = low_volt ? DIV_W'(LV_Q) : raw_q;
    end
    assign act_q = eff_q;

    // Lock-wait timer.
    synth_lock_timer #(
        .LOCK_PWR(LOCK_PWR),
        .LOCK_CHG(LOCK_CHG),
        .LOCK_SRC(LOCK_SRC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_q   (syn_en),
        .en_next(en_next),
        .cause  (cause),
        .ready  (ready)
    );

    // Frequency code for readback.
    synth_vco_calc #(
        .MINT_W  (MINT_W),
        .MFRAC_W (MFRAC_W),
        .DIV_W   (DIV_W),
        .REF_W   (REF_W),
        .INT_CODE(INT_CODE),
        .VCO_PIPE(1'b1)
    ) u_vco (
        .clk      (clk),
        .rst_n    (rst_n),
        .xtal_code(xtal_code),
        .src      (act_src),
        .mint     (act_mint),
        .mfrac    (act_mfrac),
        .q        (eff_q),
        .n        (act_n),
        .vco_code (vco_code)
    );

endmodule

// File: rtl/synth_lock_chk.sv
// Checker: temporal properties of the sequencer, seen at its ports.
// low_cnt counts enabled cycles with ready low, so the minimum wait can be
// checked without a long $past.
module synth_lock_chk #(
    parameter int MINT_W   = 10,
    parameter int DATA_W   = 10,
    parameter int LOCK_CHG = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              commit,
    input logic              syn_en,
    input logic              ready,
    input logic [MINT_W-1:0] act_mint
);

    logic [15:0] low_cnt;

    // Count cycles spent enabled but not ready, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !syn_en || ready) low_cnt <= '0;
        else if (low_cnt != 16'hFFFF)   low_cnt <= low_cnt + 1'b1;
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_mint)); // R2

    AST_PWRUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_en) |-> !ready); // R4

    AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt >= 16'(LOCK_CHG))); // R5

    AST_QUIET_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !commit && !wr_en) |=> ready); // R8

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !wr_data[1]) |=> (!ready && !syn_en)); // R9

endmodule

bind synth_lock_ctrl synth_lock_chk #(
    .MINT_W  (MINT_W),
    .DATA_W  (DATA_W),
    .LOCK_CHG(LOCK_CHG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .commit  (commit),
    .syn_en  (syn_en),
    .ready   (ready),
    .act_mint(act_mint)
);

// File: tb/synth_lock_ctrl_test.sv
`timescale 1ns/1ps
module synth_lock_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [9:0]  wr_data;
    logic        commit;
    logic        low_volt;
    logic [7:0]  xtal_code;
    logic        syn_en;
    logic        ready;
    logic [9:0]  act_mint;
    logic [9:0]  act_mfrac;
    logic [4:0]  act_q;
    logic [4:0]  act_n;
    logic        act_src;
    logic [17:0] vco_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of shadow and active settings.
    int m_mint, m_mfrac, m_q, m_n, m_src;
    int a_mint, a_mfrac, a_q, a_n, a_src;

    always #10 clk = ~clk;

    synth_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .low_volt(low_volt),
        .xtal_code(xtal_code), .syn_en(syn_en), .ready(ready),
        .act_mint(act_mint), .act_mfrac(act_mfrac), .act_q(act_q),
        .act_n(act_n), .act_src(act_src), .vco_code(vco_code)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[9:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_all(input int en);
        wr(0, m_mint);
        wr(1, m_mfrac);
        wr(2, (m_q << 5) | m_n);
        wr(3, (en << 1) | m_src);
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        a_mint = m_mint; a_mfrac = m_mfrac; a_q = m_q; a_n = m_n; a_src = m_src;
    endtask

    function automatic longint exp_vco();
        longint r, q, num, den;
        r   = a_src ? 16 : xtal_code;
        q   = low_volt ? 3 : a_q;
        num = r * (a_mint * 1024 + a_mfrac);
        den = (q + 1) * (a_n + 1) * 1024;
        return num / den;
    endfunction

    task automatic check_active(input string tag);
        check({tag, " mint"},  act_mint,  a_mint);
        check({tag, " mfrac"}, act_mfrac, a_mfrac);
        check({tag, " q"},     act_q,     low_volt ? 3 : a_q);
        check({tag, " n"},     act_n,     a_n);
        check({tag, " src"},   act_src,   a_src);
    endtask

    // After a trigger edge: ready low for n-1 more samples, high at n.
    task automatic expect_wait(input int n, input string tag);
        tick(n - 1);
        check({tag, " ready still low"}, ready, 0);
        tick(1);
        check({tag, " ready rises"}, ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        commit = 1'b0; low_volt = 1'b0; xtal_code = 8'd25;
        m_mint = 0; m_mfrac = 0; m_q = 0; m_n = 0; m_src = 0;
        a_mint = 0; a_mfrac = 0; a_q = 0; a_n = 0; a_src = 0;
        tick(3);
        check("R1 en in reset", syn_en, 0);
        check("R1 ready in reset", ready, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 en", syn_en, 0);
        check("R1 ready", ready, 0);
        check_active("R1");
        check("R1 vco", vco_code, 0);

        // R12: commit while disabled applies settings, ready stays low.
        m_mint = 50; m_mfrac = 0; m_q = 0; m_n = 1; m_src = 0;
        write_all(0);
        check("R2 before commit mint", act_mint, 0);
        do_commit();
        check_active("R12");
        tick(3);
        check("R12 ready", ready, 0);
        check("R11 vco disabled", vco_code, exp_vco());
        check("R11 vco value 625", vco_code, 625);

        // R4: power-up wait.
        wr(3, 2 | m_src);
        check("R4 en on", syn_en, 1);
        expect_wait(512, "R4");

        // R10: low voltage forces Q.
        m_q = 7; write_all(1); do_commit(); tick(130);
        low_volt = 1'b1; tick(1);
        check("R10 q forced", act_q, 3);
        check("R10 vco", vco_code, exp_vco());
        low_volt = 1'b0; tick(1);
        check("R10 q released", act_q, 7);

        // Random steps with the synthesizer enabled.
        for (int i = 0; i < 24; i++) begin
            bit mchg, schg;
            low_volt  = ($urandom % 2) != 0;
            xtal_code = 8'(5 + $urandom % 21);
            if ($urandom % 4 != 0) begin
                m_mint  = $urandom % 1024;
                m_mfrac = $urandom % 1024;
                m_q     = $urandom % 32;
                m_n     = $urandom % 32;
                m_src   = $urandom % 2;
            end
            write_all(1);
            check_active("R2 shadow only");
            mchg = (m_mint != a_mint) || (m_mfrac != a_mfrac) ||
                   (m_q != a_q) || (m_n != a_n);
            schg = (m_src != a_src);
            do_commit();
            check_active("R3 applied");
            if (mchg)      expect_wait(128, "R5");
            else if (schg) expect_wait(128, "R6");
            else begin
                check("R8 no change ready", ready, 1);
                tick(1);
                check("R8 no change ready later", ready, 1);
            end
            check("R11 vco", vco_code, exp_vco());
        end
        low_volt = 1'b0;

        // R6: a pure source switch.
        m_src = a_src ^ 1; wr(3, 2 | m_src); do_commit();
        check("R6 drop", ready, 0);
        expect_wait(128, "R6");

        // R7: commit during a wait restarts it.
        m_mint = (a_mint + 1) % 1024; wr(0, m_mint); do_commit();
        tick(50);
        m_src = a_src ^ 1; wr(3, 2 | m_src); do_commit();
        expect_wait(128, "R7 restart");

        // R9: clear enable mid-wait, then re-enable waits the full 512.
        m_n = (a_n + 1) % 32; wr(2, (m_q << 5) | m_n); do_commit();
        tick(10);
        wr(3, m_src);
        check("R9 en off", syn_en, 0);
        check("R9 ready off", ready, 0);
        wr(3, 2 | m_src);
        expect_wait(512, "R9 reenable");
        wr(3, m_src);
        check("R9 ready drops after lock", ready, 0);

        // R7: enable rise and commit in the same cycle -> 512.
        m_mint = (a_mint + 3) % 1024; wr(0, m_mint);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 10'(2 | m_src); commit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; commit = 1'b0;
        a_mint = m_mint; a_mfrac = m_mfrac; a_q = m_q; a_n = m_n; a_src = m_src;
        check_active("R3 with enable");
        expect_wait(512, "R7 combined");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule